// File: doc/BRIEF.md
# Clockless Interrupt Edge Latch

A bank of external interrupt lines that records pin transitions even when every clock in the system is stopped. The pin edge itself clocks a small per-line state flop, so the event is stored at once and no sampling clock is needed. An unmasked line that holds a recorded event drives a wake request straight to the power controller. This request is combinational from the edge-clocked state, so it works while all oscillators are off.

Software sees a copy of each line's pending state that has passed through a two-flop synchronizer into the bus clock domain. The interrupt request is built from that synchronized copy, so it is serviced once clocks are running again. Software clears a line by writing a 1 to its bit.

The clear uses a handshake in which each edge flop holds a toggle value and the bus domain holds the matching acknowledge value. Because of this, an edge that software has not yet seen through the synchronizer is never wiped out by a clear.

Top module: `exti_edge_latch`

## Requirements
- R1: After reset, `pend_rd`, `irq` and `wake` are all 0.
- R2: A rising pin edge on a line whose `rise_en` bit is 1 records an event. `pend_rd` for that line reads 1 after the second rising `clk` edge that follows the pin edge.
- R3: A falling pin edge on a line whose `fall_en` bit is 1 records an event. When both enables are 1, either edge records one.
- R4: An edge whose polarity is not enabled on that line records nothing, and `pend_rd` stays 0.
- R5: `unmask` bit 1 means the line is forwarded. A masked line still records events in `pend_rd`, but it drives neither `irq` nor `wake`.
- R6: `wake` goes to 1 as soon as an enabled edge arrives on an unmasked line, with `clk` stopped.
- R7: A `clk` edge with `clr_wr`=1 clears every line whose `clr_data` bit is 1, if that line's event had already reached `pend_rd`. Lines whose `clr_data` bit is 0 are unchanged. A line never drops from pending unless it is cleared.
- R8: An event recorded within the two `clk` cycles before a clear takes effect is not erased. Its line reads 1 in `pend_rd` again and keeps `wake` asserted.
- R9: `irq` is 1 exactly when some line has both `pend_rd` and `unmask` set.
- R10: Further edges on a line that is already pending are absorbed. A single clear leaves the line idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin | input | LINES | Clean digital pin levels |
| rise_en | input | LINES | Rising-edge trigger enable per line |
| fall_en | input | LINES | Falling-edge trigger enable per line |
| unmask | input | LINES | 1 forwards the line to irq and wake |
| clr_wr | input | 1 | Clear write strobe |
| clr_data | input | LINES | Write-1-to-clear mask |
| pend_rd | output | LINES | Synchronized pending bits |
| irq | output | 1 | Interrupt request (bus domain) |
| wake | output | 1 | Asynchronous wake request |

## Verification
The bench builds the block with `LINES=3`. This gives one line per trigger style: rising-only, falling-only and both. The masking, clear-mask and clear-collision cases can then all be observed on neighbouring lines, so any cross-talk between lines would show up. A gated bench clock brings the stopped-clock wake path within reach, and the reference model tracks the two-cycle synchronizer latency against every clear.

// File: rtl/exti_edge_latch.sv
module exti_edge_latch #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin,
  input  logic [LINES-1:0] rise_en,
  input  logic [LINES-1:0] fall_en,
  input  logic [LINES-1:0] unmask,
  input  logic             clr_wr,
  input  logic [LINES-1:0] clr_data,
  output logic [LINES-1:0] pend_rd,
  output logic             irq,
  output logic             wake
);

  logic [LINES-1:0] tog_r, tog_f;
  logic [LINES-1:0] ack_r, ack_f;
  logic [LINES-1:0] s1_r, s2_r, s1_f, s2_f;
  logic [LINES-1:0] pend_raw;
  logic [LINES-1:0] clr_sel;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic hit_r, hit_f;

    always_ff @(posedge pin[i] or negedge rst_n)
      if (!rst_n)          hit_r <= 1'b0;
      else if (rise_en[i]) hit_r <= ~ack_r[i];

    always_ff @(negedge pin[i] or negedge rst_n)
      if (!rst_n)          hit_f <= 1'b0;
      else if (fall_en[i]) hit_f <= ~ack_f[i];

    assign tog_r[i] = hit_r;
    assign tog_f[i] = hit_f;

    a_r7_no_silent_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr && pend_rd[i]) |=> pend_rd[i]);

    a_r2_sync_behind_raw: assert property (@(posedge clk) disable iff (!rst_n)
      pend_rd[i] |-> pend_raw[i]);
  end

  assign clr_sel = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_r  <= '0;
      s2_r  <= '0;
      s1_f  <= '0;
      s2_f  <= '0;
      ack_r <= '0;
      ack_f <= '0;
    end else begin
      s1_r  <= tog_r;
      s2_r  <= s1_r;
      s1_f  <= tog_f;
      s2_f  <= s1_f;
      ack_r <= (ack_r & ~clr_sel) | (s2_r & clr_sel);
      ack_f <= (ack_f & ~clr_sel) | (s2_f & clr_sel);
    end

  assign pend_raw = (tog_r ^ ack_r) | (tog_f ^ ack_f);
  assign pend_rd  = (s2_r ^ ack_r) | (s2_f ^ ack_f);
  assign irq      = |(pend_rd & unmask);
  assign wake     = |(pend_raw & unmask);

  a_r9_irq_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);

  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend_rd == '0));

endmodule

// File: tb/sim_exti_edge_latch.sv
module sim_exti_edge_latch;
  localparam int LINES = 3;
  localparam int CLK_P = 10;

  logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic [LINES-1:0] pin = '0, rise_en = '0, fall_en = '0, unmask = '0, clr_data = '0;
  logic clr_wr = 1'b0;
  logic [LINES-1:0] pend_rd;
  logic irq, wake;

  int n_cmp = 0, n_bad = 0;
  int gr[LINES], gf[LINES], ar[LINES], af[LINES];
  int hr1[LINES], hr2[LINES], hf1[LINES], hf2[LINES];

  exti_edge_latch #(.LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .pin(pin), .rise_en(rise_en), .fall_en(fall_en),
    .unmask(unmask), .clr_wr(clr_wr), .clr_data(clr_data),
    .pend_rd(pend_rd), .irq(irq), .wake(wake));

  always begin
    #(CLK_P/2);
    if (clk_run) clk = ~clk;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [LINES-1:0] exp_rd();
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = (hr2[i] != ar[i]) || (hf2[i] != af[i]);
    return v;
  endfunction

  function automatic logic [LINES-1:0] exp_raw();
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = (gr[i] != ar[i]) || (gf[i] != af[i]);
    return v;
  endfunction

  // reference model: event generations per polarity, acknowledged generation, two-cycle history
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        if (clr_wr && clr_data[i]) begin
          ar[i] = hr2[i];
          af[i] = hf2[i];
        end
        hr2[i] = hr1[i]; hr1[i] = gr[i];
        hf2[i] = hf1[i]; hf1[i] = gf[i];
      end
      #(CLK_P/4);
      check("R2 R3 R4 R7 R8 R10 pend_rd", 32'(pend_rd), 32'(exp_rd()));
      check("R5 R9 irq", 32'(irq), 32'(|(exp_rd() & unmask)));
      check("R5 R6 wake", 32'(wake), 32'(|(exp_raw() & unmask)));
    end
  end

  task automatic drive(int i, logic v);
    if (v != pin[i]) begin
      if (v && rise_en[i] && gr[i] == ar[i]) gr[i]++;
      if (!v && fall_en[i] && gf[i] == af[i]) gf[i]++;
      pin[i] = v;
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(logic [LINES-1:0] m);
    @(negedge clk);
    clr_wr = 1'b1; clr_data = m;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  initial begin
    #(CLK_P*200000);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      gr[i] = 0; gf[i] = 0; ar[i] = 0; af[i] = 0;
      hr1[i] = 0; hr2[i] = 0; hf1[i] = 0; hf2[i] = 0;
    end
    cyc(3);
    check("R1 reset pend_rd", 32'(pend_rd), 0);
    check("R1 reset irq", 32'(irq), 0);
    check("R1 reset wake", 32'(wake), 0);
    @(negedge clk); rst_n = 1'b1;
    rise_en = 3'b101; fall_en = 3'b110; unmask = 3'b111;
    cyc(2);

    // R2: rising edge on line 0, visible after two clocks
    drive(0, 1'b1);
    #1 check("R2 wake immediate", 32'(wake), 1);
    cyc(1); check("R2 not yet synced", 32'(pend_rd[0]), 0);
    cyc(1); check("R2 synced", 32'(pend_rd[0]), 1);
    clear(3'b001); cyc(1);
    check("R7 cleared", 32'(pend_rd), 0);

    // R4: falling edge on rising-only line is ignored
    drive(0, 1'b0); cyc(4);
    check("R4 disabled polarity", 32'(pend_rd[0]), 0);
    check("R4 no wake", 32'(wake), 0);
    // R4: rising edge on falling-only line
    drive(1, 1'b1); cyc(4);
    check("R4 rising on fall-only line", 32'(pend_rd[1]), 0);

    // R3: falling on line 1, then both polarities on line 2
    drive(1, 1'b0); cyc(3);
    check("R3 falling sets", 32'(pend_rd[1]), 1);
    clear(3'b010); cyc(2);
    drive(2, 1'b1); cyc(3);
    check("R3 both rise", 32'(pend_rd[2]), 1);
    clear(3'b100); cyc(2);
    check("R3 cleared before fall", 32'(pend_rd[2]), 0);
    drive(2, 1'b0); cyc(3);
    check("R3 both fall", 32'(pend_rd[2]), 1);

    // R7: writing 0 has no effect
    clear(3'b011); cyc(2);
    check("R7 zero bit keeps line", 32'(pend_rd[2]), 1);
    clear(3'b100); cyc(2);

    // R10: several edges while pending
    for (int k = 0; k < 3; k++) begin drive(0, 1'b1); cyc(1); drive(0, 1'b0); cyc(1); end
    cyc(2);
    check("R10 pending once", 32'(pend_rd[0]), 1);
    clear(3'b001); cyc(3);
    check("R10 single clear idle", 32'(pend_rd[0]), 0);

    // R5: masked line records but does not forward
    unmask = 3'b101;
    drive(1, 1'b1); cyc(1); drive(1, 1'b0); cyc(3);
    check("R5 masked pend recorded", 32'(pend_rd[1]), 1);
    check("R5 masked no irq", 32'(irq), 0);
    check("R5 masked no wake", 32'(wake), 0);
    unmask = 3'b111; #1;
    check("R9 irq on unmask", 32'(irq), 1);
    clear(3'b010); cyc(2);

    // R6: clock stopped, wake still raised
    @(negedge clk); clk_run = 1'b0;
    #(CLK_P*3);
    drive(2, 1'b1);
    #2 check("R6 wake with clock stopped", 32'(wake), 1);
    check("R6 irq waits for clock", 32'(irq), 0);
    #(CLK_P*3); clk_run = 1'b1;
    cyc(3);
    check("R6 irq after restart", 32'(irq), 1);
    clear(3'b100); cyc(2);

    // R8: edge arriving together with a clear
    @(negedge clk);
    drive(0, 1'b1); clr_wr = 1'b1; clr_data = 3'b001;
    @(negedge clk); clr_wr = 1'b0; clr_data = '0;
    check("R8 wake kept", 32'(wake), 1);
    cyc(3);
    check("R8 flag survives clear", 32'(pend_rd[0]), 1);
    clear(3'b001); cyc(3);
    check("R8 later clear works", 32'(pend_rd[0]), 0);
    drive(0, 1'b0); cyc(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule